// File: doc/BRIEF.md
# Synchronous Block Preamble Framer

This block sits on the receive side of a synchronous serial link that sends blocks as a continuous bit stream, with no start or stop bits around each character. Bit timing comes from a separate clock line: each cycle where `bit_en` is high carries one received bit, most significant bit of each byte first. While idle, the framer compares a sliding 8-bit window against the preamble at every bit position. Once it has confirmed the preamble, it fixes the byte boundary and delivers payload bytes with a valid strobe. The first payload byte also carries a start strobe.

Two preamble styles are selected by `mode`. In character mode (`mode`=0) the preamble is a run of at least two SYN characters (0x16). In flag mode (`mode`=1) it is a run of 0xFF bytes closed by the flag byte 0xFE. A postamble at a byte boundary ends the block. In character mode this is one SYN character; in flag mode it is the flag byte. The framer then raises an end strobe and goes back to hunting. Both a synchronous reset and an abort input force a return to hunting.

Top module: `sync_block_framer`

## Requirements
- R1: When `rst` is high at a clock edge, the framer enters the hunt state: `hunting`=1, and `byte_vld`, `blk_start`, `blk_end` and `byte_out` are 0.
- R2: In character mode (`mode`=0), a SYN (0x16) found at any bit position, followed by a second 0x16 in the next eight enabled bits, locks the framer. Each later group of eight enabled bits (first bit = MSB) that is not 0x16 is output on `byte_out` with a one-cycle `byte_vld`.
- R3: In character mode, 0x16 bytes that arrive after lock but before the first payload byte are discarded, with no strobe.
- R4: In character mode, an aligned 0x16 after payload has started raises `blk_end` for one cycle without `byte_vld`. The framer then returns to hunting (`hunting`=1).
- R5: In flag mode (`mode`=1), a 0xFF byte found at any bit position, followed by zero or more aligned 0xFF bytes and then an aligned 0xFE, locks the framer. The aligned bytes after that are payload, 0xFF included.
- R6: In flag mode, an aligned 0xFE after lock raises `blk_end` for one cycle without `byte_vld` and returns to hunting. A 0xFE directly after the preamble gives an empty block: `blk_end` with no `blk_start`.
- R7: `blk_start` pulses exactly once per block, in the same cycle as the `byte_vld` of the first payload byte.
- R8: The preamble is found whatever its bit offset relative to earlier stream data.
- R9: During confirmation, an aligned byte that does not continue the preamble returns the framer to hunting with no output. In character mode this is any byte other than 0x16; in flag mode any byte other than 0xFF or 0xFE.
- R10: `abort` high at a clock edge forces the hunt state. No further payload or `blk_end` follows until a new preamble is found.
- R11: Cycles with `bit_en` low change nothing, whatever `bit_in` does.
- R12: Output strobes are registered. They go high in the cycle after the edge that samples a byte's eighth enabled bit and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a cycle carrying a received bit |
| bit_in | input | 1 | Received serial bit |
| mode | input | 1 | Preamble style: 0 SYN characters, 1 ones run with flag |
| abort | input | 1 | Forces a return to hunting |
| byte_out | output | 8 | Last payload byte |
| byte_vld | output | 1 | One-cycle strobe for a new payload byte |
| blk_start | output | 1 | One-cycle strobe on the first payload byte of a block |
| blk_end | output | 1 | One-cycle strobe when the postamble is seen |
| hunting | output | 1 | High while searching for a preamble |

## Verification
Every strobe and `byte_out` is due exactly one cycle after the rising edge that samples the eighth enabled bit of a byte. `hunting` follows the same edge. The bench drives inputs on falling edges and logs outputs in a monitor on falling edges. Each strobe is therefore seen exactly once, half a period after it is registered. One directed test stops before the eighth bit of a byte and then steps edge by edge, checking that the valid strobe appears in the cycle after that bit and is gone one cycle later.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SYN_CHAR  = 8'h16;
    localparam byte_t ONES_CHAR = 8'hFF;
    localparam byte_t FLAG_CHAR = 8'hFE;

    typedef enum logic {
        PRE_SYN  = 1'b0,
        PRE_FLAG = 1'b1
    } pre_style_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_CONFIRM,
        ST_GAP,
        ST_DATA
    } fr_state_e;

    typedef struct packed {
        byte_t data;
        logic  vld;
        logic  sob;
        logic  eob;
    } fr_out_t;

    // byte searched at every bit position while hunting
    function automatic byte_t hunt_code(pre_style_e s);
        return (s == PRE_FLAG) ? ONES_CHAR : SYN_CHAR;
    endfunction

    // aligned byte that closes a block
    function automatic byte_t close_code(pre_style_e s);
        return (s == PRE_FLAG) ? FLAG_CHAR : SYN_CHAR;
    endfunction
endpackage

// File: rtl/fr_shift.sv
module fr_shift
    import framer_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win;

    assign win_next = {win[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)
            win <= '0;
        else if (en)
            win <= win_next;
    end
endmodule

// File: rtl/fr_bitpos.sv
module fr_bitpos
    import framer_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int CW = $clog2(W)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic realign,
    output logic byte_done
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] pos;

    assign byte_done = en && (pos == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (en) begin
            if (realign || pos == LAST)
                pos <= '0;
            else
                pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/fr_ctrl.sv
module fr_ctrl
    import framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic       en,
    input  pre_style_e style,
    input  byte_t      win_next,
    input  logic       byte_done,
    output logic       realign,
    output fr_out_t    out_q,
    output logic       hunting
);
    fr_state_e state;

    assign hunting = (state == ST_HUNT);
    assign realign = hunting && en && (win_next == hunt_code(style));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= ST_HUNT;
            out_q <= '0;
        end else begin
            out_q.vld <= 1'b0;
            out_q.sob <= 1'b0;
            out_q.eob <= 1'b0;
            unique case (state)
                ST_HUNT: begin
                    if (realign)
                        state <= ST_CONFIRM;
                end
                ST_CONFIRM: begin
                    if (byte_done) begin
                        if (style == PRE_SYN)
                            state <= (win_next == SYN_CHAR) ? ST_GAP : ST_HUNT;
                        else if (win_next == FLAG_CHAR)
                            state <= ST_GAP;
                        else if (win_next != ONES_CHAR)
                            state <= ST_HUNT;
                    end
                end
                ST_GAP: begin
                    if (byte_done) begin
                        if (style == PRE_SYN && win_next == SYN_CHAR) begin
                            state <= ST_GAP;
                        end else if (style == PRE_FLAG && win_next == FLAG_CHAR) begin
                            out_q.eob <= 1'b1;
                            state     <= ST_HUNT;
                        end else begin
                            out_q.data <= win_next;
                            out_q.vld  <= 1'b1;
                            out_q.sob  <= 1'b1;
                            state      <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        if (win_next == close_code(style)) begin
                            out_q.eob <= 1'b1;
                            state     <= ST_HUNT;
                        end else begin
                            out_q.data <= win_next;
                            out_q.vld  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/sync_block_framer.sv
module sync_block_framer
    import framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              mode,
    input  logic              abort,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              blk_start,
    output logic              blk_end,
    output logic              hunting
);
    byte_t   win_next;
    logic    byte_done;
    logic    realign;
    fr_out_t out_q;

    fr_shift #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en       (bit_en),
        .din      (bit_in),
        .win_next (win_next)
    );

    fr_bitpos #(.W(BYTE_W), .CW(CNT_W)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .en        (bit_en),
        .realign   (realign),
        .byte_done (byte_done)
    );

    fr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .en        (bit_en),
        .style     (pre_style_e'(mode)),
        .win_next  (win_next),
        .byte_done (byte_done),
        .realign   (realign),
        .out_q     (out_q),
        .hunting   (hunting)
    );

    assign byte_out  = out_q.data;
    assign byte_vld  = out_q.vld;
    assign blk_start = out_q.sob;
    assign blk_end   = out_q.eob;
endmodule

// File: rtl/framer_checker.sv
module framer_checker (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic abort,
    input logic byte_vld,
    input logic blk_start,
    input logic blk_end,
    input logic hunting
);
    p_start_has_byte_r7: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> byte_vld);

    p_end_without_byte_r4: assert property (@(posedge clk) disable iff (rst)
        blk_end |-> !byte_vld);

    p_end_back_to_hunt_r6: assert property (@(posedge clk) disable iff (rst)
        blk_end |-> hunting);

    p_single_cycle_vld_r12: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    p_abort_hunts_r10: assert property (@(posedge clk) disable iff (rst)
        abort |=> (hunting && !byte_vld && !blk_end));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> (!byte_vld && !blk_start && !blk_end));

    p_at_most_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_vld, blk_end}));
endmodule

bind sync_block_framer framer_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .abort     (abort),
    .byte_vld  (byte_vld),
    .blk_start (blk_start),
    .blk_end   (blk_end),
    .hunting   (hunting)
);

// File: tb/sync_block_framer_test.sv
`timescale 1ns/1ps
module sync_block_framer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       mode = 1'b0;
    logic       abort = 1'b0;
    logic [7:0] byte_out;
    logic       byte_vld, blk_start, blk_end, hunting;

    always #4 clk = ~clk;   // 125 MHz

    sync_block_framer uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .mode(mode),
        .abort(abort), .byte_out(byte_out), .byte_vld(byte_vld),
        .blk_start(blk_start), .blk_end(blk_end), .hunting(hunting)
    );

    typedef struct packed {
        logic            mode;
        logic [3:0]      nin;
        logic [7:0][7:0] din;   // sent from the left
        logic [2:0]      nexp;
        logic [3:0][7:0] dexp;  // expected from the left
        logic            eob;
    } vec_t;

    // V1 covers R3 (extra SYNs); V4 and V5 cover R9; V6 is the empty flag block (R6)
    localparam vec_t VECS [7] = '{
        '{1'b0, 4'd6, {8'h00,8'h16,8'h16,8'hA5,8'h3C,8'h16,8'h00,8'h00}, 3'd2, {8'hA5,8'h3C,8'h00,8'h00}, 1'b1},
        '{1'b0, 4'd7, {8'h00,8'h16,8'h16,8'h16,8'h16,8'h5A,8'h16,8'h00}, 3'd1, {8'h5A,8'h00,8'h00,8'h00}, 1'b1},
        '{1'b1, 4'd7, {8'h00,8'hFF,8'hFF,8'hFE,8'h12,8'h34,8'hFE,8'h00}, 3'd2, {8'h12,8'h34,8'h00,8'h00}, 1'b1},
        '{1'b1, 4'd6, {8'h00,8'hFF,8'hFE,8'hFF,8'h81,8'hFE,8'h00,8'h00}, 3'd2, {8'hFF,8'h81,8'h00,8'h00}, 1'b1},
        '{1'b0, 4'd5, {8'h00,8'h16,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00}, 3'd0, 32'h0, 1'b0},
        '{1'b1, 4'd4, {8'h00,8'hFF,8'h77,8'h00,8'h00,8'h00,8'h00,8'h00}, 3'd0, 32'h0, 1'b0},
        '{1'b1, 4'd4, {8'h00,8'hFF,8'hFE,8'hFE,8'h00,8'h00,8'h00,8'h00}, 3'd0, 32'h0, 1'b1}
    };

    int n_checks = 0;
    int n_fail = 0;
    int got_n = 0, sob_n = 0, eob_n = 0;
    logic sob_bad = 1'b0;
    logic [7:0] got [16];

    // event log, sampled half a cycle after each rising edge
    always @(negedge clk) begin
        if (blk_start) begin
            sob_n <= sob_n + 1;
            if (!(byte_vld && got_n == 0)) sob_bad <= 1'b1;
        end
        if (blk_end) eob_n <= eob_n + 1;
        if (byte_vld) begin
            if (got_n < 16) got[got_n] <= byte_out;
            got_n <= got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1;
        got_n = 0; sob_n = 0; eob_n = 0; sob_bad = 1'b0;
    endtask

    // one enabled bit, then one idle cycle with bit_in inverted (R11)
    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; bit_in = ~b;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R1 reset state
        chk(hunting == 1'b1, "R1", hunting, 1);
        chk({byte_vld, blk_start, blk_end} == 3'b0, "R1", {byte_vld, blk_start, blk_end}, 0);
        chk(byte_out == 8'h00, "R1", byte_out, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < 7; v++) begin
            mode = VECS[v].mode;
            clear_log();
            for (int i = 0; i < int'(VECS[v].nin); i++) send_byte(VECS[v].din[7-i]);
            repeat (3) @(negedge clk);
            chk(got_n == int'(VECS[v].nexp), VECS[v].mode ? "R5" : "R2", got_n, VECS[v].nexp);
            for (int i = 0; i < int'(VECS[v].nexp); i++)
                chk(got[i] == VECS[v].dexp[3-i], VECS[v].mode ? "R5" : "R2", got[i], VECS[v].dexp[3-i]);
            chk(sob_n == ((VECS[v].nexp != 0) ? 1 : 0) && !sob_bad, "R7", sob_n, (VECS[v].nexp != 0) ? 1 : 0);
            chk(eob_n == int'(VECS[v].eob), VECS[v].mode ? "R6" : "R4", eob_n, VECS[v].eob);
            chk(hunting == 1'b1, VECS[v].eob ? (VECS[v].mode ? "R6" : "R4") : "R9", hunting, 1);
            pulse_abort();
        end

        // R8: preamble at an odd bit offset
        mode = 1'b0;
        clear_log();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_byte(8'h16); send_byte(8'h16); send_byte(8'hC3); send_byte(8'h16);
        repeat (3) @(negedge clk);
        chk(got_n == 1, "R8", got_n, 1);
        chk(got[0] == 8'hC3, "R8", got[0], 8'hC3);
        chk(eob_n == 1, "R8", eob_n, 1);

        // R10: abort in the middle of a block
        clear_log();
        send_byte(8'h00); send_byte(8'h16); send_byte(8'h16); send_byte(8'hA5);
        pulse_abort();
        send_byte(8'h3C); send_byte(8'h55);
        repeat (3) @(negedge clk);
        chk(got_n == 1, "R10", got_n, 1);
        chk(eob_n == 0, "R10", eob_n, 0);
        chk(hunting == 1'b1, "R10", hunting, 1);

        // R1: synchronous reset mid-preamble
        clear_log();
        send_byte(8'h00); send_byte(8'h16); send_byte(8'h16);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(hunting == 1'b1, "R1", hunting, 1);
        send_byte(8'h7E);
        repeat (3) @(negedge clk);
        chk(got_n == 0, "R1", got_n, 0);

        // R11: SYN patterns with bit_en low do nothing
        clear_log();
        for (int k = 0; k < 3; k++)
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk); bit_in = SYN_BITS[i]; bit_en = 1'b0;
            end
        repeat (3) @(negedge clk);
        chk(hunting == 1'b1, "R11", hunting, 1);
        chk(got_n == 0 && eob_n == 0, "R11", got_n + eob_n, 0);

        // R12: strobe timing around the eighth bit
        send_byte(8'h00); send_byte(8'h16); send_byte(8'h16);
        for (int i = 7; i >= 1; i--) send_bit(RAW[i]);
        @(negedge clk);
        chk(byte_vld == 1'b0, "R12", byte_vld, 0);
        bit_in = RAW[0]; bit_en = 1'b1;
        @(posedge clk); #1;
        chk(byte_vld == 1'b1 && blk_start == 1'b1, "R12", {byte_vld, blk_start}, 2'b11);
        chk(byte_out == RAW, "R12", byte_out, RAW);
        @(negedge clk); bit_en = 1'b0;
        @(posedge clk); #1;
        chk(byte_vld == 1'b0 && blk_start == 1'b0, "R12", {byte_vld, blk_start}, 0);
        pulse_abort();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    localparam logic [7:0] SYN_BITS = 8'h16;
    localparam logic [7:0] RAW = 8'h81;
endmodule